// File: doc/BRIEF.md
# Scatter-Gather Transmit Descriptor Walker

This block walks a chain of transmit frame descriptors in host memory and turns each one into a stream of fragment commands for a downstream data mover. Software places descriptors in memory and starts the walker with the address of the first one. The walker fetches 32-bit descriptor words through a single-word read port that has separate request and response handshakes. For every fragment with a non-zero byte count, it hands an address, a byte count and an end-of-frame flag to a valid/ready command port.

Every descriptor is 8-byte aligned. Its first word is the address of the next descriptor. Two-word fragment slots follow at computed offsets: each slot holds a start address, which may have any byte alignment, and a length/control word. A flag in the length/control word closes the frame. After a frame closes, the walker follows the stored next pointer, and a null pointer returns it to idle. A misaligned descriptor pointer stops the walker. A descriptor whose last slot does not close the frame is truncated and reported.

Top module: `sg_desc_walker`

## Requirements
- R1: A start request is taken only while `idle_o` is high. A start with a zero head pointer issues no memory read and leaves the walker idle. While idle, the walker drives no memory request and no command.
- R2: For a descriptor at base B, the walker first reads word B+0 (next pointer). It then reads, for slot n = 0, 1, …, the address word at B+8+8n followed by the length/control word at B+12+8n. It keeps at most one read outstanding, issues the next request only after the previous response, and holds the request address stable until `mem_req_ready_i` is sampled high. All request addresses are 4-byte aligned.
- R3: A fragment command carries the slot's address word unchanged and the length/control bits 12:0 as `cmd_len_o`. Bit 31 is the frame-end flag and appears as `cmd_last_o`. Bits 30:13 have no effect on any output.
- R4: While `cmd_valid_o` is high and `cmd_ready_i` is low, `cmd_valid_o`, `cmd_addr_o`, `cmd_len_o` and `cmd_last_o` stay unchanged.
- R5: A slot whose bits 12:0 are zero produces no command, and `cmd_len_o` is never zero while `cmd_valid_o` is high. If such a slot has bit 31 set, it still ends the frame.
- R6: `frame_done_o` is high for exactly one cycle per frame. That cycle follows the clock edge at which the frame's final step completed: either the handshake of the last command, or the arrival of a zero-length final length word.
- R7: After a frame ends, the walker continues at the stored next pointer if that pointer is non-zero and 8-byte aligned. If the pointer is zero, it returns to idle.
- R8: A head or next pointer with any of bits 2:0 set raises `align_err_o` and returns the walker to idle. No read is issued at that pointer.
- R9: If slot 63 lacks bit 31, its command (if any) carries `cmd_last_o` = 1, the frame ends, `malformed_err_o` rises, and the walk continues at the next pointer.
- R10: `align_err_o` and `malformed_err_o` stay high until the next accepted start request, which clears both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request to begin a walk |
| head_ptr_i | input | 32 | Address of the first descriptor |
| idle_o | output | 1 | Walker is idle and accepts a start |
| mem_req_valid_o | output | 1 | Read request valid |
| mem_req_ready_i | input | 1 | Read request accepted |
| mem_req_addr_o | output | 32 | Byte address of the word to read |
| mem_rsp_valid_i | input | 1 | Read data valid |
| mem_rsp_data_i | input | 32 | Read data |
| cmd_valid_o | output | 1 | Fragment command valid |
| cmd_ready_i | input | 1 | Fragment command accepted |
| cmd_addr_o | output | 32 | Fragment start address |
| cmd_len_o | output | 13 | Fragment byte count |
| cmd_last_o | output | 1 | Fragment ends its frame |
| frame_done_o | output | 1 | One-cycle pulse per completed frame |
| align_err_o | output | 1 | Misaligned descriptor pointer seen |
| malformed_err_o | output | 1 | Descriptor slot 63 lacked the frame-end flag |

## Verification
The bench walks a three-descriptor chain whose slots mix normal lengths, a zero-length middle slot, reserved bits set, the maximum 13-bit count and a zero-length closing slot. These cases show whether reserved bits and empty slots leak into commands and whether frame ends are signalled in order. A full 64-slot descriptor is run twice: once closed on slot 63 and once never closed. The pair separates correct slot counting from an off-by-one truncation. Misaligned head and next pointers, a null head, and a start pulse issued mid-walk show that reads stop at exactly the right place and that errors clear only on a new start. Random ready and response latencies show whether request and command values stay stable under back-pressure.

// File: rtl/sg_walk_pkg.sv
package sg_walk_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_WAIT = 2'd2,
        ST_EMIT = 2'd3
    } walk_st_e;

    // which word of the descriptor is being fetched
    typedef enum logic [1:0] {
        PH_NEXT = 2'd0,
        PH_FADDR = 2'd1,
        PH_FLEN = 2'd2
    } walk_ph_e;
endpackage

// File: rtl/sg_addr_gen.sv
module sg_addr_gen
    import sg_walk_pkg::*;
#(
    parameter int AW         = 32,
    parameter int IDX_W      = 6,
    parameter int HDR_BYTES  = 8,
    parameter int SLOT_BYTES = 8
) (
    input  logic [AW-1:0]    base_i,
    input  logic [IDX_W-1:0] idx_i,
    input  walk_ph_e         ph_i,
    output logic [AW-1:0]    addr_o
);
    localparam int LEN_OFS = SLOT_BYTES / 2;

    logic [AW-1:0] slot_ofs;

    always_comb begin
        slot_ofs = AW'(HDR_BYTES) + AW'(idx_i) * AW'(SLOT_BYTES);
        unique case (ph_i)
            PH_FADDR: addr_o = base_i + slot_ofs;
            PH_FLEN:  addr_o = base_i + slot_ofs + AW'(LEN_OFS);
            default:  addr_o = base_i;
        endcase
    end
endmodule

// File: rtl/sg_frag_decode.sv
module sg_frag_decode #(
    parameter int DW       = 32,
    parameter int LEN_W    = 13,
    parameter int FLAG_BIT = 31
) (
    input  logic [DW-1:0]    word_i,
    output logic [LEN_W-1:0] len_o,
    output logic             last_o,
    output logic             zero_o
);
    logic unused_rsvd;

    assign len_o       = word_i[LEN_W-1:0];
    assign last_o      = word_i[FLAG_BIT];
    assign zero_o      = (word_i[LEN_W-1:0] == '0);
    assign unused_rsvd = ^word_i[FLAG_BIT-1:LEN_W];
endmodule

// File: rtl/sg_desc_walker.sv
module sg_desc_walker
    import sg_walk_pkg::*;
#(
    parameter int AW         = 32,
    parameter int LEN_W      = 13,
    parameter int MAX_FRAGS  = 64,
    parameter int ALIGN_BITS = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [AW-1:0]    head_ptr_i,
    output logic             idle_o,
    output logic             mem_req_valid_o,
    input  logic             mem_req_ready_i,
    output logic [AW-1:0]    mem_req_addr_o,
    input  logic             mem_rsp_valid_i,
    input  logic [31:0]      mem_rsp_data_i,
    output logic             cmd_valid_o,
    input  logic             cmd_ready_i,
    output logic [AW-1:0]    cmd_addr_o,
    output logic [LEN_W-1:0] cmd_len_o,
    output logic             cmd_last_o,
    output logic             frame_done_o,
    output logic             align_err_o,
    output logic             malformed_err_o
);
    localparam int IDX_W = $clog2(MAX_FRAGS);
    localparam logic [IDX_W-1:0] IDX_END = IDX_W'(MAX_FRAGS - 1);

    typedef struct packed {
        walk_st_e          st;
        walk_ph_e          ph;
        logic [AW-1:0]     base;
        logic [AW-1:0]     nxt;
        logic [IDX_W-1:0]  idx;
        logic [AW-1:0]     faddr;
        logic              cmd_v;
        logic [AW-1:0]     c_addr;
        logic [LEN_W-1:0]  c_len;
        logic              c_last;
        logic              fdone;
        logic              align_err;
        logic              mal_err;
    } walk_regs_t;

    walk_regs_t q, d;
    logic [LEN_W-1:0] dec_len;
    logic             dec_last, dec_zero;
    logic             adv, adv_last, last_eff;

    sg_addr_gen #(.AW(AW), .IDX_W(IDX_W), .HDR_BYTES(8), .SLOT_BYTES(8)) i_addr (
        .base_i(q.base), .idx_i(q.idx), .ph_i(q.ph), .addr_o(mem_req_addr_o)
    );

    sg_frag_decode #(.DW(32), .LEN_W(LEN_W), .FLAG_BIT(31)) i_dec (
        .word_i(mem_rsp_data_i), .len_o(dec_len), .last_o(dec_last), .zero_o(dec_zero)
    );

    always_comb begin
        d        = q;
        d.fdone  = 1'b0;
        adv      = 1'b0;
        adv_last = 1'b0;
        last_eff = dec_last || (q.idx == IDX_END);
        unique case (q.st)
            ST_IDLE: begin
                if (start_i) begin
                    d.align_err = 1'b0;
                    d.mal_err   = 1'b0;
                    if (|head_ptr_i[ALIGN_BITS-1:0]) begin
                        d.align_err = 1'b1;
                    end else if (head_ptr_i != '0) begin
                        d.base = head_ptr_i;
                        d.idx  = '0;
                        d.ph   = PH_NEXT;
                        d.st   = ST_REQ;
                    end
                end
            end
            ST_REQ: begin
                if (mem_req_ready_i) d.st = ST_WAIT;
            end
            ST_WAIT: begin
                if (mem_rsp_valid_i) begin
                    unique case (q.ph)
                        PH_NEXT: begin
                            d.nxt = mem_rsp_data_i;
                            d.ph  = PH_FADDR;
                            d.st  = ST_REQ;
                        end
                        PH_FADDR: begin
                            d.faddr = mem_rsp_data_i;
                            d.ph    = PH_FLEN;
                            d.st    = ST_REQ;
                        end
                        default: begin
                            if (!dec_last && (q.idx == IDX_END)) d.mal_err = 1'b1;
                            if (!dec_zero) begin
                                d.cmd_v  = 1'b1;
                                d.c_addr = q.faddr;
                                d.c_len  = dec_len;
                                d.c_last = last_eff;
                                d.st     = ST_EMIT;
                            end else begin
                                adv      = 1'b1;
                                adv_last = last_eff;
                            end
                        end
                    endcase
                end
            end
            default: begin
                if (cmd_ready_i) begin
                    d.cmd_v  = 1'b0;
                    adv      = 1'b1;
                    adv_last = q.c_last;
                end
            end
        endcase

        if (adv) begin
            if (adv_last) begin
                d.fdone = 1'b1;
                if (q.nxt == '0) begin
                    d.st = ST_IDLE;
                end else if (|q.nxt[ALIGN_BITS-1:0]) begin
                    d.align_err = 1'b1;
                    d.st        = ST_IDLE;
                end else begin
                    d.base = q.nxt;
                    d.idx  = '0;
                    d.ph   = PH_NEXT;
                    d.st   = ST_REQ;
                end
            end else begin
                d.idx = q.idx + 1'b1;
                d.ph  = PH_FADDR;
                d.st  = ST_REQ;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign idle_o          = (q.st == ST_IDLE);
    assign mem_req_valid_o = (q.st == ST_REQ);
    assign cmd_valid_o     = q.cmd_v;
    assign cmd_addr_o      = q.c_addr;
    assign cmd_len_o       = q.c_len;
    assign cmd_last_o      = q.c_last;
    assign frame_done_o    = q.fdone;
    assign align_err_o     = q.align_err;
    assign malformed_err_o = q.mal_err;

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        idle_o |-> (!mem_req_valid_o && !cmd_valid_o));
    a_r2_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid_o && !mem_req_ready_i) |=> (mem_req_valid_o && $stable(mem_req_addr_o)));
    a_r2_word_addr: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid_o |-> (mem_req_addr_o[1:0] == 2'b00));
    a_r4_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_o && !cmd_ready_i) |=> (cmd_valid_o && $stable(cmd_addr_o)
            && $stable(cmd_len_o) && $stable(cmd_last_o)));
    a_r5_no_empty_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o |-> (cmd_len_o != '0));
    a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done_o |=> !frame_done_o);
    a_r10_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_o && start_i) |=> !malformed_err_o);
endmodule

// File: tb/test_sg_desc_walker.sv
`timescale 1ns/1ps
module test_sg_desc_walker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] head_ptr_i = '0;
    logic        idle_o;
    logic        mem_req_valid_o;
    logic        mem_req_ready_i = 1'b0;
    logic [31:0] mem_req_addr_o;
    logic        mem_rsp_valid_i = 1'b0;
    logic [31:0] mem_rsp_data_i = '0;
    logic        cmd_valid_o;
    logic        cmd_ready_i = 1'b0;
    logic [31:0] cmd_addr_o;
    logic [12:0] cmd_len_o;
    logic        cmd_last_o;
    logic        frame_done_o;
    logic        align_err_o;
    logic        malformed_err_o;

    always #4 clk = ~clk;

    sg_desc_walker i_sg_desc_walker (.*);

    typedef struct {
        bit          is_frame;
        logic [31:0] a;
        logic [12:0] l;
        bit          last;
    } ev_t;

    logic [31:0] mem [logic [31:0]];
    ev_t         evq[$];
    logic [31:0] rdq[$];
    bit          exp_align, exp_mal;
    int          checks = 0, fails = 0;

    function automatic logic [31:0] rd(logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic put_frag(logic [31:0] b, int n, logic [31:0] a, logic [31:0] w);
        mem[32'(b + 8 + 8*n)]  = a;
        mem[32'(b + 12 + 8*n)] = w;
    endtask

    function automatic void ref_walk(logic [31:0] head);
        logic [31:0] p, nx, a, w;
        bit last;
        ev_t e;
        exp_align = 0;
        exp_mal   = 0;
        if (head == 0) return;
        if (head[2:0] != 0) begin exp_align = 1; return; end
        p = head;
        forever begin
            rdq.push_back(p);
            nx = rd(p);
            for (int n = 0; n < 64; n++) begin
                rdq.push_back(32'(p + 8 + 8*n));  a = rd(32'(p + 8 + 8*n));
                rdq.push_back(32'(p + 12 + 8*n)); w = rd(32'(p + 12 + 8*n));
                last = w[31];
                if (n == 63 && !last) begin exp_mal = 1; last = 1; end
                if (w[12:0] != 0) begin
                    e.is_frame = 0; e.a = a; e.l = w[12:0]; e.last = last;
                    evq.push_back(e);
                end
                if (last) begin
                    e.is_frame = 1; e.a = 0; e.l = 0; e.last = 1;
                    evq.push_back(e);
                    break;
                end
            end
            if (nx == 0) break;
            if (nx[2:0] != 0) begin exp_align = 1; break; end
            p = nx;
        end
    endfunction

    // environment model and per-cycle comparison
    initial begin
        bit          pending = 0;
        int          lat = 0;
        logic [31:0] pdata = '0;
        bit          prev_hold = 0;
        logic [31:0] pa = '0;
        logic [12:0] pl = '0;
        bit          plast = 0;
        ev_t         e;
        forever begin
            @(negedge clk);
            mem_rsp_valid_i = 1'b0;
            if (!rst_n) continue;
            if (pending) begin
                lat--;
                if (lat == 0) begin
                    mem_rsp_valid_i = 1'b1;
                    mem_rsp_data_i  = pdata;
                    pending = 0;
                end
            end
            if (frame_done_o) begin
                if (evq.size() == 0 || !evq[0].is_frame)
                    chk(0, "R6", "unexpected frame_done", 1, 0);
                else begin
                    void'(evq.pop_front());
                    chk(1, "R6", "frame_done", 1, 1);
                end
            end
            if (prev_hold)
                chk(cmd_valid_o && cmd_addr_o == pa && cmd_len_o == pl && cmd_last_o == plast,
                    "R4", "command changed under back-pressure", {cmd_addr_o, 19'(cmd_len_o), cmd_last_o},
                    {pa, 19'(pl), plast});
            cmd_ready_i = ($urandom % 4) != 0;
            if (cmd_valid_o && cmd_ready_i) begin
                if (evq.size() == 0 || evq[0].is_frame)
                    chk(0, "R5", "unexpected command", {cmd_addr_o, 19'(cmd_len_o)}, 0);
                else begin
                    e = evq.pop_front();
                    chk(cmd_addr_o == e.a, "R3", "cmd address", cmd_addr_o, e.a);
                    chk(cmd_len_o == e.l, "R3", "cmd length", cmd_len_o, e.l);
                    chk(cmd_last_o == e.last, "R9", "cmd last flag", cmd_last_o, e.last);
                end
            end
            prev_hold = cmd_valid_o && !cmd_ready_i;
            pa = cmd_addr_o; pl = cmd_len_o; plast = cmd_last_o;
            if (mem_req_valid_o && (pending || mem_rsp_valid_i))
                chk(0, "R2", "second read outstanding", 1, 0);
            mem_req_ready_i = ($urandom % 3) != 0;
            if (mem_req_valid_o && mem_req_ready_i) begin
                if (rdq.size() == 0)
                    chk(0, "R2", "unexpected read", mem_req_addr_o, 0);
                else begin
                    logic [31:0] ea;
                    ea = rdq.pop_front();
                    chk(mem_req_addr_o == ea, "R2", "read address", mem_req_addr_o, ea);
                end
                pending = 1;
                lat     = 1 + int'($urandom % 3);
                pdata   = rd(mem_req_addr_o);
            end
        end
    end

    task automatic run(logic [31:0] head, bit poke_busy, string tag);
        int n = 0;
        ref_walk(head);
        @(negedge clk);
        start_i = 1'b1; head_ptr_i = head;
        @(negedge clk);
        start_i = 1'b0;
        if (poke_busy) begin
            repeat (3) @(negedge clk);
            chk(!idle_o, "R1", "walker busy before stray start", idle_o, 0);
            start_i = 1'b1; head_ptr_i = 32'h0000_8000;
            @(negedge clk);
            start_i = 1'b0;
        end
        while (!idle_o && n < 20000) begin
            @(negedge clk);
            n++;
        end
        chk(n < 20000, "R7", {tag, " walk finished"}, n, 0);
        repeat (2) @(negedge clk);
        chk(evq.size() == 0, "R7", {tag, " all commands and frames seen"}, evq.size(), 0);
        chk(rdq.size() == 0, "R2", {tag, " all reads issued"}, rdq.size(), 0);
        chk(align_err_o == exp_align, "R8", {tag, " alignment error"}, align_err_o, exp_align);
        chk(malformed_err_o == exp_mal, "R9", {tag, " malformed error"}, malformed_err_o, exp_mal);
        evq.delete();
        rdq.delete();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        // chain: 0x1000 -> 0x2000 -> 0x3000 -> null
        mem[32'h1000] = 32'h0000_2000;
        put_frag(32'h1000, 0, 32'h0001_0003, 32'h0000_0040);
        put_frag(32'h1000, 1, 32'h0002_0000, 32'h7FFF_E000);
        put_frag(32'h1000, 2, 32'h0003_0005, 32'h8001_2005);
        mem[32'h2000] = 32'h0000_3000;
        put_frag(32'h2000, 0, 32'h0000_4000, 32'h8000_1FFF);
        mem[32'h3000] = 32'h0000_0000;
        put_frag(32'h3000, 0, 32'h0000_5000, 32'h0000_0010);
        put_frag(32'h3000, 1, 32'h0000_5555, 32'h8000_0000);
        // 64 slots, never closed
        mem[32'h8000] = 32'h0;
        for (int n = 0; n < 64; n++) put_frag(32'h8000, n, 32'h0010_0000 + 32'(n), 32'(n + 1));
        // 64 slots closed on slot 63, misaligned next pointer
        mem[32'h9000] = 32'h0000_A004;
        for (int n = 0; n < 64; n++)
            put_frag(32'h9000, n, 32'h0020_0001 + 32'(n), (n == 63) ? 32'h8000_0007 : 32'(n + 2));

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(idle_o == 1'b1, "R1", "reset idle", idle_o, 1);
        chk(!mem_req_valid_o && !cmd_valid_o && !frame_done_o, "R1", "reset outputs quiet",
            {mem_req_valid_o, cmd_valid_o, frame_done_o}, 0);
        chk(!align_err_o && !malformed_err_o, "R10", "reset errors clear",
            {align_err_o, malformed_err_o}, 0);

        run(32'h0000_0000, 0, "R1 null head");
        chk(idle_o, "R1", "idle after null head", idle_o, 1);
        run(32'h0000_1000, 1, "R5 chain with stray start");
        run(32'h0000_8000, 0, "R9 unclosed descriptor");
        run(32'h0000_9000, 0, "R10 closed on slot 63, bad next");
        run(32'h0000_1002, 0, "R8 misaligned head");
        run(32'h0000_1000, 0, "R10 clean after error");
        chk(!align_err_o, "R10", "align error cleared by start", align_err_o, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule